// File: doc/BRIEF.md
# Receiver Immunity Parameter Programmer

This block turns a single tuning command into masked updates of seven shadow copies of receiver control registers. A command carries an opcode that picks one of five knobs and a small argument. Three knobs take a level: noise immunity (0 to 4), spur immunity (0 to 7) and first-step (0 to 2). Two knobs are binary: OFDM weak-signal detection (on or off) and the CCK weak-signal threshold (low or high). The block looks up the tuning values for the requested setting, inserts each value into its own bit field of the right shadow register, and leaves every other bit as it was.

For every knob the block holds the current setting and a pair of event counters. One counter counts moves to a higher setting and the other counts moves to a lower setting. Rewriting the same setting counts nothing. A valid command is answered with a one-cycle acknowledge in the cycle after it is presented. A command with an unknown opcode or an out-of-range level is answered with a one-cycle error pulse and changes nothing. A policy engine above this block decides which command to issue. The shadow registers are handed to whatever carries them to the receiver.

Top module: `rx_immunity_prog`

## Requirements
- R1: While reset is asserted and after it is released, acknowledge and error are 0, all seven shadow registers are 0, all knob settings are 0 and all counters are 0.
- R2: Opcode 0 (noise level L, 0..4) writes signed 8-bit sh_size[27:20], 7-bit sh_agc[21:15] (coarse high), 8-bit sh_agc[14:7] (coarse low) and 8-bit sh_fsig[19:12] (FIR power). Levels 0..3 give -55, -14, -64, -78. Level 4 gives -62, -12, -70, -80. All are two's complement truncated to the field width.
- R3: Opcode 1 (spur level L, 0..7) writes sh_tim5[6:1] = 2*(L+1).
- R4: Opcode 2 (first-step level L, 0..2) writes sh_fsig[5:0] = 4*L.
- R5: Opcode 3 with a nonzero argument turns weak-signal detection on. It writes sh_corr[6:0]=0x4D, sh_corr[13:7]=0x40, sh_corr[18:14]=16, sh_corrlo[7:1]=50, sh_corrlo[14:8]=40, sh_corrlo[20:15]=48, and sets sh_corrlo[0].
- R6: Opcode 3 with a zero argument turns weak-signal detection off. It writes 127, 127 and 31 into the three sh_corr fields and 127, 127 and 63 into the three sh_corrlo fields, and clears sh_corrlo[0].
- R7: Opcode 4 writes sh_cck[13:10] = 6 when the argument is nonzero (high) and 8 when it is zero (low).
- R8: A command changes only its target fields. Every other bit of every shadow register keeps its value, including a field that shares a register with the target, such as first-step beside FIR power.
- R9: An opcode of 5..7, a noise level of 5 or more, a spur level of 8 or more, or a first-step level of 3 or more raises the error output for one cycle and changes no shadow, setting or counter.
- R10: An accepted command increments the knob's up counter when the new setting is greater than the old one and its down counter when it is smaller. For binary knobs, on or high counts as up. An unchanged setting increments neither counter.
- R11: A command presented with cmd_valid high at a clock edge is answered in the following cycle only, by exactly one of acknowledge or error. With cmd_valid low nothing changes and both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Knob select (0 noise, 1 spur, 2 first-step, 3 OFDM weak, 4 CCK threshold) |
| cmd_arg | input | ARG_W | Level, or nonzero for on/high |
| cmd_ack | output | 1 | Command accepted (one-cycle pulse) |
| cmd_err | output | 1 | Command rejected (one-cycle pulse) |
| sh_size | output | 32 | Shadow: desired-size register |
| sh_agc | output | 32 | Shadow: gain-control register |
| sh_fsig | output | 32 | Shadow: signal-search register |
| sh_corr | output | 32 | Shadow: correlation register |
| sh_corrlo | output | 32 | Shadow: low correlation register |
| sh_cck | output | 32 | Shadow: CCK detect register |
| sh_tim5 | output | 32 | Shadow: cycle-power timing register |
| lvl_noise | output | 3 | Current noise immunity level |
| lvl_spur | output | 3 | Current spur immunity level |
| lvl_step | output | 2 | Current first-step level |
| weak_ofdm_on | output | 1 | OFDM weak-signal detection enabled |
| cck_thr_high | output | 1 | CCK threshold set to high |
| noise_up_cnt | output | CNT_W | Noise level increases |
| noise_dn_cnt | output | CNT_W | Noise level decreases |
| spur_up_cnt | output | CNT_W | Spur level increases |
| spur_dn_cnt | output | CNT_W | Spur level decreases |
| step_up_cnt | output | CNT_W | First-step increases |
| step_dn_cnt | output | CNT_W | First-step decreases |
| ofdm_on_cnt | output | CNT_W | Weak-signal detection turned on |
| ofdm_off_cnt | output | CNT_W | Weak-signal detection turned off |
| cck_hi_cnt | output | CNT_W | CCK threshold moved to high |
| cck_lo_cnt | output | CNT_W | CCK threshold moved to low |

## Verification
A shadow field insertion and a statistic update fall in the same clock edge. A noise command also rewrites two fields of the shared gain-control register in that edge. Each opcode is swept through every argument value, in ascending order and again in descending order with repeats. This drives increases, decreases and no-change rewrites through the same edge as the field writes. After each command the bench compares all seven shadows, all settings and all counters against an arithmetic model. A first-step level is set before a noise change, so the bench can see that the sharing neighbour field survives.

// File: rtl/rxi_pkg.sv
package rxi_pkg;

  localparam int REG_W     = 32;
  localparam int NUM_KNOBS = 5;
  localparam int KNOB_W    = 3;

  localparam int K_NOISE = 0;
  localparam int K_SPUR  = 1;
  localparam int K_STEP  = 2;
  localparam int K_OFDM  = 3;
  localparam int K_CCK   = 4;

  localparam int NOISE_LEVELS = 5;
  localparam int SPUR_LEVELS  = 8;
  localparam int STEP_LEVELS  = 3;

  typedef enum logic [2:0] {
    OP_NOISE = 3'd0,
    OP_SPUR  = 3'd1,
    OP_STEP  = 3'd2,
    OP_OFDM  = 3'd3,
    OP_CCK   = 3'd4
  } rxi_op_e;

  // field placement: lsb, width
  localparam int F_TOT_L   = 20, F_TOT_W   = 8;
  localparam int F_CLO_L   = 7,  F_CLO_W   = 8;
  localparam int F_CHI_L   = 15, F_CHI_W   = 7;
  localparam int F_FIR_L   = 12, F_FIR_W   = 8;
  localparam int F_STEP_L  = 0,  F_STEP_W  = 6;
  localparam int F_CYC_L   = 1,  F_CYC_W   = 6;
  localparam int F_M1_L    = 0,  F_M1_W    = 7;
  localparam int F_M2_L    = 7,  F_M2_W    = 7;
  localparam int F_M2C_L   = 14, F_M2C_W   = 5;
  localparam int F_SELF_L  = 0,  F_SELF_W  = 1;
  localparam int F_M1LO_L  = 1,  F_M1LO_W  = 7;
  localparam int F_M2LO_L  = 8,  F_M2LO_W  = 7;
  localparam int F_M2CL_L  = 15, F_M2CL_W  = 6;
  localparam int F_CCK_L   = 10, F_CCK_W   = 4;

  typedef logic [REG_W-1:0] reg_t;

  typedef struct packed {
    reg_t size;
    reg_t agc;
    reg_t fsig;
    reg_t corr;
    reg_t corrlo;
    reg_t cck;
    reg_t tim5;
  } rxi_shadow_t;

  function automatic reg_t put_fld(input reg_t base, input int lsb,
                                   input int w, input reg_t val);
    reg_t one;
    reg_t msk;
    one = {{(REG_W-1){1'b0}}, 1'b1};
    msk = ((one << w) - one) << lsb;
    return (base & ~msk) | ((val << lsb) & msk);
  endfunction

  function automatic reg_t sx8(input logic signed [7:0] v);
    return {{(REG_W-8){v[7]}}, v};
  endfunction

  function automatic reg_t noise_tot(input logic [KNOB_W-1:0] l);
    return (l == 3'd4) ? sx8(-8'sd62) : sx8(-8'sd55);
  endfunction

  function automatic reg_t noise_chi(input logic [KNOB_W-1:0] l);
    return (l == 3'd4) ? sx8(-8'sd12) : sx8(-8'sd14);
  endfunction

  function automatic reg_t noise_clo(input logic [KNOB_W-1:0] l);
    return (l == 3'd4) ? sx8(-8'sd70) : sx8(-8'sd64);
  endfunction

  function automatic reg_t noise_fir(input logic [KNOB_W-1:0] l);
    return (l == 3'd4) ? sx8(-8'sd80) : sx8(-8'sd78);
  endfunction

  function automatic reg_t spur_cyc(input logic [KNOB_W-1:0] l);
    reg_t z;
    z = {{(REG_W-KNOB_W){1'b0}}, l};
    return (z << 1) + reg_t'(2);
  endfunction

  function automatic reg_t step_val(input logic [KNOB_W-1:0] l);
    reg_t z;
    z = {{(REG_W-KNOB_W){1'b0}}, l};
    return z << 2;
  endfunction

endpackage

// File: rtl/rxi_cmd_check.sv
module rxi_cmd_check
  import rxi_pkg::*;
#(
  parameter int ARG_W = 4
) (
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [ARG_W-1:0]     cmd_arg,
  output logic                 accept,
  output logic                 reject,
  output logic [NUM_KNOBS-1:0] knob_en,
  output logic [KNOB_W-1:0]    knob_lvl
);

  localparam logic [31:0] ARG_ONE = 32'd1;

  logic [31:0] arg_ext;
  logic        arg_nz;
  logic        in_range;

  assign arg_ext = {{(32-ARG_W){1'b0}}, cmd_arg};
  assign arg_nz  = |cmd_arg;

  always_comb begin
    in_range = 1'b0;
    knob_lvl = cmd_arg[KNOB_W-1:0];
    unique case (cmd_op)
      OP_NOISE: in_range = arg_ext < 32'(NOISE_LEVELS);
      OP_SPUR:  in_range = arg_ext < 32'(SPUR_LEVELS);
      OP_STEP:  in_range = arg_ext < 32'(STEP_LEVELS);
      OP_OFDM: begin
        in_range = 1'b1;
        knob_lvl = {{(KNOB_W-1){1'b0}}, arg_nz};
      end
      OP_CCK: begin
        in_range = 1'b1;
        knob_lvl = {{(KNOB_W-1){1'b0}}, arg_nz};
      end
      default:  in_range = 1'b0;
    endcase
  end

  assign accept = cmd_valid & in_range;
  assign reject = cmd_valid & ~in_range;

  for (genvar k = 0; k < NUM_KNOBS; k++) begin : g_en
    assign knob_en[k] = accept && ({29'd0, cmd_op} == ARG_ONE * k);
  end

endmodule

// File: rtl/rxi_knob.sv
module rxi_knob #(
  parameter int LVL_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] new_lvl,
  output logic [LVL_W-1:0] lvl,
  output logic [CNT_W-1:0] up_cnt,
  output logic [CNT_W-1:0] dn_cnt
);

  logic [LVL_W-1:0] lvl_d;
  logic [CNT_W-1:0] up_d;
  logic [CNT_W-1:0] dn_d;
  logic             go_up;
  logic             go_dn;

  assign go_up = en && (new_lvl > lvl);
  assign go_dn = en && (new_lvl < lvl);

  always_comb begin
    lvl_d = lvl;
    up_d  = up_cnt;
    dn_d  = dn_cnt;
    if (en)    lvl_d = new_lvl;
    if (go_up) up_d  = up_cnt + 1'b1;
    if (go_dn) dn_d  = dn_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl    <= '0;
      up_cnt <= '0;
      dn_cnt <= '0;
    end else begin
      lvl    <= lvl_d;
      up_cnt <= up_d;
      dn_cnt <= dn_d;
    end
  end

endmodule

// File: rtl/rxi_shadow.sv
module rxi_shadow
  import rxi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_KNOBS-1:0] knob_en,
  input  logic [KNOB_W-1:0]    knob_lvl,
  output rxi_shadow_t          sh
);

  rxi_shadow_t sh_d;
  logic        on;

  assign on = knob_lvl[0];

  always_comb begin
    sh_d = sh;
    if (knob_en[K_NOISE]) begin
      sh_d.size = put_fld(sh.size, F_TOT_L, F_TOT_W, noise_tot(knob_lvl));
      sh_d.agc  = put_fld(put_fld(sh.agc, F_CLO_L, F_CLO_W, noise_clo(knob_lvl)),
                          F_CHI_L, F_CHI_W, noise_chi(knob_lvl));
      sh_d.fsig = put_fld(sh.fsig, F_FIR_L, F_FIR_W, noise_fir(knob_lvl));
    end
    if (knob_en[K_SPUR]) begin
      sh_d.tim5 = put_fld(sh.tim5, F_CYC_L, F_CYC_W, spur_cyc(knob_lvl));
    end
    if (knob_en[K_STEP]) begin
      sh_d.fsig = put_fld(sh.fsig, F_STEP_L, F_STEP_W, step_val(knob_lvl));
    end
    if (knob_en[K_OFDM]) begin
      sh_d.corr = put_fld(
                    put_fld(
                      put_fld(sh.corr, F_M1_L, F_M1_W, on ? reg_t'(8'h4D) : reg_t'(127)),
                      F_M2_L, F_M2_W, on ? reg_t'(8'h40) : reg_t'(127)),
                    F_M2C_L, F_M2C_W, on ? reg_t'(16) : reg_t'(31));
      sh_d.corrlo = put_fld(
                      put_fld(
                        put_fld(
                          put_fld(sh.corrlo, F_M1LO_L, F_M1LO_W, on ? reg_t'(50) : reg_t'(127)),
                          F_M2LO_L, F_M2LO_W, on ? reg_t'(40) : reg_t'(127)),
                        F_M2CL_L, F_M2CL_W, on ? reg_t'(48) : reg_t'(63)),
                      F_SELF_L, F_SELF_W, on ? reg_t'(1) : reg_t'(0));
    end
    if (knob_en[K_CCK]) begin
      sh_d.cck = put_fld(sh.cck, F_CCK_L, F_CCK_W, on ? reg_t'(6) : reg_t'(8));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= sh_d;
  end

endmodule

// File: rtl/rx_immunity_prog.sv
module rx_immunity_prog
  import rxi_pkg::*;
#(
  parameter int ARG_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [ARG_W-1:0] cmd_arg,
  output logic             cmd_ack,
  output logic             cmd_err,
  output logic [31:0]      sh_size,
  output logic [31:0]      sh_agc,
  output logic [31:0]      sh_fsig,
  output logic [31:0]      sh_corr,
  output logic [31:0]      sh_corrlo,
  output logic [31:0]      sh_cck,
  output logic [31:0]      sh_tim5,
  output logic [2:0]       lvl_noise,
  output logic [2:0]       lvl_spur,
  output logic [1:0]       lvl_step,
  output logic             weak_ofdm_on,
  output logic             cck_thr_high,
  output logic [CNT_W-1:0] noise_up_cnt,
  output logic [CNT_W-1:0] noise_dn_cnt,
  output logic [CNT_W-1:0] spur_up_cnt,
  output logic [CNT_W-1:0] spur_dn_cnt,
  output logic [CNT_W-1:0] step_up_cnt,
  output logic [CNT_W-1:0] step_dn_cnt,
  output logic [CNT_W-1:0] ofdm_on_cnt,
  output logic [CNT_W-1:0] ofdm_off_cnt,
  output logic [CNT_W-1:0] cck_hi_cnt,
  output logic [CNT_W-1:0] cck_lo_cnt
);

  logic                 accept;
  logic                 reject;
  logic [NUM_KNOBS-1:0] knob_en;
  logic [KNOB_W-1:0]    knob_lvl;
  logic                 ack_d;
  logic                 err_d;
  rxi_shadow_t          sh;
  logic [KNOB_W-1:0]    lvl_q [NUM_KNOBS];
  logic [CNT_W-1:0]     up_q  [NUM_KNOBS];
  logic [CNT_W-1:0]     dn_q  [NUM_KNOBS];

  rxi_cmd_check #(.ARG_W(ARG_W)) u_check (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_arg   (cmd_arg),
    .accept    (accept),
    .reject    (reject),
    .knob_en   (knob_en),
    .knob_lvl  (knob_lvl)
  );

  rxi_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .knob_en  (knob_en),
    .knob_lvl (knob_lvl),
    .sh       (sh)
  );

  for (genvar k = 0; k < NUM_KNOBS; k++) begin : g_knob
    rxi_knob #(.LVL_W(KNOB_W), .CNT_W(CNT_W)) u_knob (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (knob_en[k]),
      .new_lvl (knob_lvl),
      .lvl     (lvl_q[k]),
      .up_cnt  (up_q[k]),
      .dn_cnt  (dn_q[k])
    );
  end

  always_comb begin
    ack_d = accept;
    err_d = reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ack <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      cmd_ack <= ack_d;
      cmd_err <= err_d;
    end
  end

  assign sh_size   = sh.size;
  assign sh_agc    = sh.agc;
  assign sh_fsig   = sh.fsig;
  assign sh_corr   = sh.corr;
  assign sh_corrlo = sh.corrlo;
  assign sh_cck    = sh.cck;
  assign sh_tim5   = sh.tim5;

  assign lvl_noise    = lvl_q[K_NOISE];
  assign lvl_spur     = lvl_q[K_SPUR];
  assign lvl_step     = lvl_q[K_STEP][1:0];
  assign weak_ofdm_on = lvl_q[K_OFDM][0];
  assign cck_thr_high = lvl_q[K_CCK][0];

  assign noise_up_cnt = up_q[K_NOISE];
  assign noise_dn_cnt = dn_q[K_NOISE];
  assign spur_up_cnt  = up_q[K_SPUR];
  assign spur_dn_cnt  = dn_q[K_SPUR];
  assign step_up_cnt  = up_q[K_STEP];
  assign step_dn_cnt  = dn_q[K_STEP];
  assign ofdm_on_cnt  = up_q[K_OFDM];
  assign ofdm_off_cnt = dn_q[K_OFDM];
  assign cck_hi_cnt   = up_q[K_CCK];
  assign cck_lo_cnt   = dn_q[K_CCK];

endmodule

// File: rtl/rx_immunity_prog_chk.sv
module rx_immunity_prog_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ack,
  input logic             cmd_err,
  input logic [31:0]      sh_size,
  input logic [31:0]      sh_agc,
  input logic [31:0]      sh_fsig,
  input logic [31:0]      sh_tim5,
  input logic [2:0]       lvl_noise,
  input logic [2:0]       lvl_spur,
  input logic [1:0]       lvl_step,
  input logic [CNT_W-1:0] noise_up_cnt,
  input logic [CNT_W-1:0] spur_dn_cnt,
  input logic [CNT_W-1:0] spur_up_cnt
);

  // R11
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ack && cmd_err));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!cmd_ack && !cmd_err));

  // R9
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> ($stable(sh_size) && $stable(sh_agc) && $stable(sh_fsig) &&
                 $stable(sh_tim5) && $stable(lvl_noise) && $stable(lvl_spur) &&
                 $stable(lvl_step)));

  // R9
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_noise <= 3'd4) && (lvl_step <= 2'd2));

  // R10
  noise_up_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_up_cnt != $past(noise_up_cnt)) |-> (cmd_ack && (lvl_noise > $past(lvl_noise))));

  // R10
  spur_dn_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spur_dn_cnt != $past(spur_dn_cnt)) |-> (cmd_ack && (lvl_spur < $past(lvl_spur))));

  // R10
  spur_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(lvl_spur) |-> ($stable(spur_up_cnt) && $stable(spur_dn_cnt)));

  // R3
  spur_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack && (lvl_spur != $past(lvl_spur))) |-> (sh_tim5[6:1] == ({3'd0, lvl_spur} * 6'd2 + 6'd2)));

endmodule

bind rx_immunity_prog rx_immunity_prog_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rx_immunity_prog_bench.sv
`timescale 1ns/1ps
module rx_immunity_prog_bench;

  localparam int ARG_W = 4;
  localparam int CNT_W = 8;

  logic             clk;
  logic             rst_n;
  logic             cmd_valid;
  logic [2:0]       cmd_op;
  logic [ARG_W-1:0] cmd_arg;
  logic             cmd_ack, cmd_err;
  logic [31:0]      sh_size, sh_agc, sh_fsig, sh_corr, sh_corrlo, sh_cck, sh_tim5;
  logic [2:0]       lvl_noise, lvl_spur;
  logic [1:0]       lvl_step;
  logic             weak_ofdm_on, cck_thr_high;
  logic [CNT_W-1:0] noise_up_cnt, noise_dn_cnt, spur_up_cnt, spur_dn_cnt;
  logic [CNT_W-1:0] step_up_cnt, step_dn_cnt, ofdm_on_cnt, ofdm_off_cnt;
  logic [CNT_W-1:0] cck_hi_cnt, cck_lo_cnt;

  int n_chk = 0;
  int n_bad = 0;

  rx_immunity_prog #(.ARG_W(ARG_W), .CNT_W(CNT_W)) u_rx_immunity_prog (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected model
  logic [31:0] e_sh [7];   // size agc fsig corr corrlo cck tim5
  int          e_lvl [5];
  logic [7:0]  e_up [5];
  logic [7:0]  e_dn [5];

  function automatic logic [31:0] ins(input logic [31:0] b, input int lsb,
                                      input int w, input int v);
    logic [31:0] m;
    logic [31:0] vv;
    m  = ((32'd1 << w) - 32'd1) << lsb;
    vv = v;
    return (b & ~m) | ((vv << lsb) & m);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(sh_size   == e_sh[0], tag, "sh_size",   sh_size,   e_sh[0]);
    chk(sh_agc    == e_sh[1], tag, "sh_agc",    sh_agc,    e_sh[1]);
    chk(sh_fsig   == e_sh[2], tag, "sh_fsig",   sh_fsig,   e_sh[2]);
    chk(sh_corr   == e_sh[3], tag, "sh_corr",   sh_corr,   e_sh[3]);
    chk(sh_corrlo == e_sh[4], tag, "sh_corrlo", sh_corrlo, e_sh[4]);
    chk(sh_cck    == e_sh[5], tag, "sh_cck",    sh_cck,    e_sh[5]);
    chk(sh_tim5   == e_sh[6], tag, "sh_tim5",   sh_tim5,   e_sh[6]);
    chk({lvl_noise, lvl_spur, lvl_step, weak_ofdm_on, cck_thr_high} ==
        {3'(e_lvl[0]), 3'(e_lvl[1]), 2'(e_lvl[2]), 1'(e_lvl[3]), 1'(e_lvl[4])},
        tag, "levels",
        {lvl_noise, lvl_spur, lvl_step, weak_ofdm_on, cck_thr_high},
        {3'(e_lvl[0]), 3'(e_lvl[1]), 2'(e_lvl[2]), 1'(e_lvl[3]), 1'(e_lvl[4])});
    // R10 counters
    chk({noise_up_cnt, noise_dn_cnt, spur_up_cnt, spur_dn_cnt, step_up_cnt} ==
        {e_up[0], e_dn[0], e_up[1], e_dn[1], e_up[2]}, "R10", "counters_a",
        {noise_up_cnt, noise_dn_cnt, spur_up_cnt, spur_dn_cnt, step_up_cnt},
        {e_up[0], e_dn[0], e_up[1], e_dn[1], e_up[2]});
    chk({step_dn_cnt, ofdm_on_cnt, ofdm_off_cnt, cck_hi_cnt, cck_lo_cnt} ==
        {e_dn[2], e_up[3], e_dn[3], e_up[4], e_dn[4]}, "R10", "counters_b",
        {step_dn_cnt, ofdm_on_cnt, ofdm_off_cnt, cck_hi_cnt, cck_lo_cnt},
        {e_dn[2], e_up[3], e_dn[3], e_up[4], e_dn[4]});
  endtask

  task automatic do_cmd(input int op, input int arg);
    bit    valid;
    int    nl;
    string tag;
    valid = 1'b0;
    nl    = arg;
    tag   = "R9";
    case (op)
      0: begin valid = arg < 5; if (valid) tag = "R2"; end
      1: begin valid = arg < 8; if (valid) tag = "R3"; end
      2: begin valid = arg < 3; if (valid) tag = "R4"; end
      3: begin valid = 1'b1; nl = (arg != 0); tag = (arg != 0) ? "R5" : "R6"; end
      4: begin valid = 1'b1; nl = (arg != 0); tag = "R7"; end
      default: valid = 1'b0;
    endcase
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_arg   = ARG_W'(arg);
    @(posedge clk);
    #1;
    if (valid) begin
      case (op)
        0: begin
          e_sh[0] = ins(e_sh[0], 20, 8, (nl == 4) ? -62 : -55);
          e_sh[1] = ins(e_sh[1], 15, 7, (nl == 4) ? -12 : -14);
          e_sh[1] = ins(e_sh[1], 7,  8, (nl == 4) ? -70 : -64);
          e_sh[2] = ins(e_sh[2], 12, 8, (nl == 4) ? -80 : -78);
        end
        1: e_sh[6] = ins(e_sh[6], 1, 6, 2 * (nl + 1));
        2: e_sh[2] = ins(e_sh[2], 0, 6, 4 * nl);
        3: begin
          e_sh[3] = ins(e_sh[3], 0,  7, nl ? 8'h4D : 127);
          e_sh[3] = ins(e_sh[3], 7,  7, nl ? 8'h40 : 127);
          e_sh[3] = ins(e_sh[3], 14, 5, nl ? 16 : 31);
          e_sh[4] = ins(e_sh[4], 1,  7, nl ? 50 : 127);
          e_sh[4] = ins(e_sh[4], 8,  7, nl ? 40 : 127);
          e_sh[4] = ins(e_sh[4], 15, 6, nl ? 48 : 63);
          e_sh[4] = ins(e_sh[4], 0,  1, nl);
        end
        default: e_sh[5] = ins(e_sh[5], 10, 4, nl ? 6 : 8);
      endcase
      if (nl > e_lvl[op]) e_up[op] = e_up[op] + 8'd1;
      if (nl < e_lvl[op]) e_dn[op] = e_dn[op] + 8'd1;
      e_lvl[op] = nl;
    end
    chk({cmd_ack, cmd_err} == {valid, !valid}, valid ? "R11" : "R9", "ack_err",
        {cmd_ack, cmd_err}, {valid, !valid});
    compare_all(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(posedge clk);
    #1;
    chk({cmd_ack, cmd_err} == 2'b00, "R11", "pulse_end", {cmd_ack, cmd_err}, 2'b00);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) e_sh[i] = '0;
    for (int i = 0; i < 5; i++) begin e_lvl[i] = 0; e_up[i] = '0; e_dn[i] = '0; end
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_op    = '0;
    cmd_arg   = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk({cmd_ack, cmd_err} == 2'b00, "R1", "ack_err", {cmd_ack, cmd_err}, 2'b00);
    compare_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    compare_all("R1");

    // ascending sweeps across all arguments for the level knobs
    for (int op = 0; op < 3; op++)
      for (int a = 0; a < 16; a++) do_cmd(op, a);
    // descending with repeats: down counts and unchanged rewrites (R10)
    for (int a = 4; a >= 0; a--) begin do_cmd(0, a); do_cmd(0, a); end
    for (int a = 7; a >= 0; a--) do_cmd(1, a);
    for (int a = 2; a >= 0; a--) begin do_cmd(2, a); do_cmd(2, a); end
    // binary knobs R5 R6 R7
    do_cmd(3, 1); do_cmd(3, 1); do_cmd(3, 0); do_cmd(3, 5); do_cmd(3, 0); do_cmd(3, 0);
    do_cmd(4, 1); do_cmd(4, 9); do_cmd(4, 0); do_cmd(4, 0); do_cmd(4, 2);
    // unknown opcodes R9
    for (int op = 5; op < 8; op++) begin do_cmd(op, 0); do_cmd(op, 3); end
    // R8: noise change keeps neighbouring first-step field
    do_cmd(2, 2);
    do_cmd(0, 4);
    chk(sh_fsig[5:0] == 6'd8, "R8", "step_kept", 64'(sh_fsig[5:0]), 64'd8);
    chk(sh_fsig[19:12] == 8'hB0, "R8", "fir_set", 64'(sh_fsig[19:12]), 64'hB0);
    do_cmd(1, 3);
    chk(sh_fsig[19:12] == 8'hB0 && sh_fsig[5:0] == 6'd8, "R8", "fsig_untouched_by_spur",
        64'(sh_fsig), 64'h000B0008);
    // R11: idle cycles with stray opcode change nothing
    @(negedge clk);
    cmd_op  = 3'd0;
    cmd_arg = 4'd1;
    repeat (3) @(posedge clk);
    #1;
    chk({cmd_ack, cmd_err} == 2'b00, "R11", "idle", {cmd_ack, cmd_err}, 2'b00);
    compare_all("R11");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule